// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses for one burst of a synchronous DRAM read or write. A start strobe captures a start column and a four-bit mode field. From the next clock on, the block emits one column address per cycle, together with a valid flag. A last flag marks the closing beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned block of columns whose size equals the burst length. Only the low column bits walk. They follow either a sequential order or an interleaved (XOR) order. The upper bits stay fixed.

A full-page burst walks the whole column space sequentially and wraps at the page end. It runs until a terminate input ends it. A new start strobe during a burst abandons the current burst. Mode codes that are not supported raise an error flag, and the burst is then run as a single beat.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start, valid_o, last_o and mode_err_o are low.
- R2: A start_i sampled high at a clock edge makes the first beat appear in the following cycle. That beat has valid_o high and col_o equal to the start column. One new address follows per cycle while valid_o stays high.
- R3: The mode field is decoded as follows. Bits 2..0 hold the length code: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives full page. Bit 3 selects the order: 0 is sequential and 1 is interleaved.
- R4: In sequential order, beat n of a burst of length L has low log2(L) bits equal to (start + n) mod L. The remaining upper column bits equal those of the start column.
- R5: In interleaved order, beat n has low log2(L) bits equal to the start column's low bits XOR n. The upper column bits are unchanged.
- R6: last_o is high only on beat L-1 of a fixed-length burst. valid_o is low in the next cycle unless a new start was sampled.
- R7: A full-page burst counts sequentially through every column and wraps from the top column to zero. It never raises last_o and keeps going until terminated.
- R8: A term_i sampled high during an active beat makes that beat the final one, and valid_o is low in the next cycle. This holds for any burst type.
- R9: Length codes 100, 101 and 110, and full page combined with interleaved order, run as a single beat at the start column. On that beat last_o and mode_err_o are high.
- R10: A start_i sampled during an active burst abandons that burst. The first beat of the new burst appears in the following cycle.
- R11: term_i while no burst is active has no effect: valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst with the column and mode present this cycle |
| start_col_i | input | COL_W | Start column |
| mode_i | input | 4 | Bits 2..0 length code, bit 3 order (1 = interleaved) |
| term_i | input | 1 | End the active burst after the current beat |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is present on col_o |
| last_o | output | 1 | Final beat of a fixed-length burst |
| mode_err_o | output | 1 | Current beat comes from an unsupported mode |

## Verification
The bench builds the block with an 8-bit column (COL_W = 8). At that width a full-page burst can be driven across the wrap from column 0xFF back to 0x00 within a few cycles. Start columns with set upper bits show that the aligned block base holds for lengths 2, 4 and 8 in both orders. The 8-bit width also keeps the abort, terminate and error cases short enough to be checked beat by beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  localparam int MODE_W   = 4;
  localparam int ORDER_BIT = 3;
endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [MODE_W-1:0] mode_i,
  output logic [COL_W-1:0]  mask_o,
  output logic              page_o,
  output logic              inter_o,
  output logic              err_o
);
  logic [2:0] code;
  logic       order;

  assign code  = mode_i[2:0];
  assign order = mode_i[ORDER_BIT];

  always_comb begin
    mask_o  = '0;
    page_o  = 1'b0;
    inter_o = order;
    err_o   = 1'b0;
    case (code)
      LEN_1:    mask_o = '0;
      LEN_2:    mask_o = COL_W'(1);
      LEN_4:    mask_o = COL_W'(3);
      LEN_8:    mask_o = COL_W'(7);
      LEN_PAGE: begin
        if (order) begin
          err_o   = 1'b1;
          inter_o = 1'b0;
        end else begin
          mask_o = '1;
          page_o = 1'b1;
        end
      end
      default: begin
        err_o   = 1'b1;
        inter_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             inter_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_off;
  logic [COL_W-1:0] xor_off;
  logic [COL_W-1:0] off;

  assign seq_off = base_i + cnt_i;
  assign xor_off = base_i ^ cnt_i;
  assign off     = inter_i ? xor_off : seq_off;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? off[b] : base_i[b];
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  input  logic             inter_i,
  input  logic             err_i,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] cnt_q,
  output logic [COL_W-1:0] mask_q,
  output logic             page_q,
  output logic             inter_q,
  output logic             err_q,
  output logic             active_q,
  output logic             final_o
);
  logic [COL_W-1:0] base_d, cnt_d, mask_d;
  logic             page_d, inter_d, err_d, active_d;
  logic             load_en, step_en;

  assign final_o = active_q && !page_q && (cnt_q == mask_q);
  assign load_en = start_i;
  assign step_en = active_q && !start_i;

  always_comb begin
    base_d   = base_q;
    cnt_d    = cnt_q;
    mask_d   = mask_q;
    page_d   = page_q;
    inter_d  = inter_q;
    err_d    = err_q;
    active_d = active_q;
    if (load_en) begin
      base_d   = col_i;
      cnt_d    = '0;
      mask_d   = mask_i;
      page_d   = page_i;
      inter_d  = inter_i;
      err_d    = err_i;
      active_d = 1'b1;
    end else if (step_en) begin
      if (term_i || final_o) begin
        active_d = 1'b0;
      end else begin
        cnt_d = cnt_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
      page_q   <= 1'b0;
      inter_q  <= 1'b0;
      err_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      base_q   <= base_d;
      cnt_q    <= cnt_d;
      mask_q   <= mask_d;
      page_q   <= page_d;
      inter_q  <= inter_d;
      err_q    <= err_d;
      active_q <= active_d;
    end
  end

  AST_START_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_q && cnt_q == '0); // R2
  AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && term_i && !start_i |=> !active_q); // R8
  AST_IDLE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && !start_i |=> !active_q); // R11
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && start_i |=> active_q && cnt_q == '0); // R10
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              mode_err_o
);
  logic [COL_W-1:0] dec_mask, base_q, cnt_q, mask_q;
  logic             dec_page, dec_inter, dec_err;
  logic             page_q, inter_q, err_q, active_q, final_beat;

  burst_mode_decode #(.COL_W(COL_W)) u_dec (
    .mode_i  (mode_i),
    .mask_o  (dec_mask),
    .page_o  (dec_page),
    .inter_o (dec_inter),
    .err_o   (dec_err)
  );

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .term_i   (term_i),
    .col_i    (start_col_i),
    .mask_i   (dec_mask),
    .page_i   (dec_page),
    .inter_i  (dec_inter),
    .err_i    (dec_err),
    .base_q   (base_q),
    .cnt_q    (cnt_q),
    .mask_q   (mask_q),
    .page_q   (page_q),
    .inter_q  (inter_q),
    .err_q    (err_q),
    .active_q (active_q),
    .final_o  (final_beat)
  );

  burst_addr_calc #(.COL_W(COL_W)) u_addr (
    .base_i  (base_q),
    .cnt_i   (cnt_q),
    .mask_i  (mask_q),
    .inter_i (inter_q),
    .col_o   (col_o)
  );

  assign valid_o    = active_q;
  assign last_o     = final_beat;
  assign mode_err_o = active_q && err_q;

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !valid_o); // R6
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err_o |-> last_o); // R9
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !start_i && !last_o && !term_i && !page_q |=>
      ((col_o & ~mask_q) == $past(col_o & ~mask_q))); // R4
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && page_q |-> !last_o); // R7
endmodule

// File: tb/burst_col_gen_test.sv
`timescale 1ns/1ps
module burst_col_gen_test;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [3:0]       mode_i;
  logic             term_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, mode_err_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [COL_W-1:0] q_col[$];
  bit               q_last[$];
  bit               q_err[$];
  string            q_tag[$];

  always #4 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .mode_i(mode_i), .term_i(term_i), .col_o(col_o), .valid_o(valid_o),
    .last_o(last_o), .mode_err_o(mode_err_o)
  );

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int len,
                                               bit inter, int n);
    logic [COL_W-1:0] m, off;
    m   = COL_W'(len - 1);
    off = inter ? (s ^ COL_W'(n)) : (s + COL_W'(n));
    return (s & ~m) | (off & m);
  endfunction

  task automatic push_beats(logic [COL_W-1:0] s, int len, bit inter, bit err,
                            int count, bit fixed, string tag);
    for (int n = 0; n < count; n++) begin
      q_col.push_back(exp_col(s, len, inter, n));
      q_last.push_back(fixed && (n == len - 1));
      q_err.push_back(err);
      q_tag.push_back(tag);
    end
  endtask

  task automatic pulse_start(logic [COL_W-1:0] s, logic [3:0] m);
    start_i = 1'b1; start_col_i = s; mode_i = m;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic chk_idle(string tag);
    total++;
    if (valid_o !== 1'b0 || last_o !== 1'b0 || mode_err_o !== 1'b0) begin
      bad++;
      $display("FAIL %s: valid=%0b last=%0b err=%0b expected 0 0 0",
               tag, valid_o, last_o, mode_err_o);
    end
  endtask

  task automatic fixed_burst(logic [COL_W-1:0] s, logic [3:0] m, int len,
                             bit inter, string tag);
    push_beats(s, len, inter, 1'b0, len, 1'b1, tag);
    pulse_start(s, m);
    wait_cycles(len);
    chk_idle({tag, " end of burst (R6)"});
  endtask

  // monitor: compares each beat against the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done && valid_o === 1'b1) begin
      total++;
      if (q_col.size() == 0) begin
        bad++;
        $display("FAIL R6/R8 extra beat: col=%0h last=%0b expected no beat",
                 col_o, last_o);
      end else begin
        logic [COL_W-1:0] ec; bit el, ee; string t;
        ec = q_col.pop_front(); el = q_last.pop_front();
        ee = q_err.pop_front(); t = q_tag.pop_front();
        if (col_o !== ec || last_o !== el || mode_err_o !== ee) begin
          bad++;
          $display("FAIL %s: col=%0h last=%0b err=%0b expected col=%0h last=%0b err=%0b",
                   t, col_o, last_o, mode_err_o, ec, el, ee);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; mode_i = '0; term_i = 1'b0;
    wait_cycles(3);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    wait_cycles(2);
    chk_idle("R1 after reset");

    // R2 R3 single beat
    fixed_burst(8'h37, 4'b0000, 1, 1'b0, "R2 len1");
    // R4 sequential with wrap in block, upper bits kept
    fixed_burst(8'hA5, 4'b0010, 4, 1'b0, "R4 seq len4");
    fixed_burst(8'h5E, 4'b0011, 8, 1'b0, "R4 seq len8");
    fixed_burst(8'hC3, 4'b0001, 2, 1'b0, "R4 seq len2");
    // R5 interleaved
    fixed_burst(8'h95, 4'b1011, 8, 1'b1, "R5 intl len8");
    fixed_burst(8'h4B, 4'b1010, 4, 1'b1, "R5 intl len4");
    fixed_burst(8'h11, 4'b1001, 2, 1'b1, "R5 intl len2");

    // R7 full page across the page wrap, ended by R8 terminate
    push_beats(8'hFC, 256, 1'b0, 1'b0, 8, 1'b0, "R7 page wrap");
    pulse_start(8'hFC, 4'b0111);
    wait_cycles(7);
    term_i = 1'b1;
    wait_cycles(1);
    term_i = 1'b0;
    chk_idle("R8 page terminated");

    // R8 terminate in a fixed burst after 3 beats
    push_beats(8'h20, 8, 1'b0, 1'b0, 3, 1'b1, "R8 early term");
    pulse_start(8'h20, 4'b0011);
    wait_cycles(2);
    term_i = 1'b1;
    wait_cycles(1);
    term_i = 1'b0;
    chk_idle("R8 fixed terminated");

    // R9 bad codes and page+interleaved
    push_beats(8'h66, 1, 1'b0, 1'b1, 1, 1'b1, "R9 code100");
    pulse_start(8'h66, 4'b0100);
    wait_cycles(1);
    chk_idle("R9 code100 single");
    push_beats(8'h7A, 1, 1'b0, 1'b1, 1, 1'b1, "R9 page intl");
    pulse_start(8'h7A, 4'b1111);
    wait_cycles(1);
    chk_idle("R9 page intl single");
    push_beats(8'h0F, 1, 1'b0, 1'b1, 1, 1'b1, "R9 code110");
    pulse_start(8'h0F, 4'b0110);
    wait_cycles(1);
    chk_idle("R9 code110 single");

    // R10 restart during a burst
    push_beats(8'h80, 8, 1'b0, 1'b0, 3, 1'b1, "R10 aborted");
    push_beats(8'h2D, 4, 1'b1, 1'b0, 4, 1'b1, "R10 new burst");
    pulse_start(8'h80, 4'b0011);
    wait_cycles(2);
    pulse_start(8'h2D, 4'b1010);
    wait_cycles(4);
    chk_idle("R10 after new burst");

    // R11 terminate while idle
    term_i = 1'b1;
    wait_cycles(3);
    chk_idle("R11 idle term");
    term_i = 1'b0;
    fixed_burst(8'hE9, 4'b0010, 4, 1'b0, "R11 burst after idle term");

    total++;
    if (q_col.size() != 0) begin
      bad++;
      $display("FAIL R2 missing beats: left=%0d expected 0", q_col.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule